// File: doc/BRIEF.md
# Channel Status Block Buffer

This block gathers the channel status bit carried by each frame of a decoded two-channel digital audio stream. Channels A and B are kept apart. Each channel's bits go into an assembly store that holds one whole block of 192 frames, which is 24 bytes per channel. Frame n of a block is written to byte n/8 at bit n%8, so bits are packed least significant bit first.

A transfer copies the assembly store into a buffer the host can see. It happens only when a complete block has been counted from a start-marked frame with no loss of alignment. While the copy is under way, a one-cycle event flag is raised for the interrupt logic.

The host reaches the visible buffer through a simple request port. A write stores one byte into the chosen channel. A read returns either the byte of the selected channel, or both bytes as a pair (A first, then B) on two consecutive cycles. A reserve control keeps the first five visible bytes out of every transfer, so the host can own those bytes.

Top module: `cs_block_buffer`

## Requirements
- R1: Frame n of a block (n = 0..191, frame 0 carrying the start marker) stores its channel A and channel B bits at bit n%8 of byte n/8 of that channel's assembly store. Assembled bits become readable only after a transfer, and reads before it return the earlier visible contents.
- R2: The frame that completes 192 frames counted from a start-marked frame causes a transfer at the next clock edge. `xfer_o` is high for exactly the one cycle that ends at that edge, and the transfer replaces the visible buffer with the assembled block.
- R3: A block is dropped without any transfer in either of two cases. The first is a start marker arriving in the middle of a block, which restarts counting at frame 0. The second is a frame arriving after frame 191 without a start marker, which drops alignment until the next start marker.
- R4: While `reserve_i` is 1, visible bytes 0 to 4 of both channels are left unchanged by transfers. While it is 0, every byte is replaced.
- R5: A write (`req_i`=1, `we_i`=1) stores `wdata_i` into byte `addr_i` of channel `chan_sel_i` (0 = A, 1 = B). A write that lands on the same edge as a transfer takes precedence over it.
- R6: A one-byte read (`req_i`=1, `we_i`=0, `pair_i`=0) yields `rvalid_o`=1 in the next cycle, with `rdata_o` holding the byte of channel `chan_sel_i` at `addr_i`.
- R7: A pair read (`pair_i`=1) yields the channel A byte in the next cycle and the channel B byte of the same address in the cycle after it.
- R8: A read request sampled during the second beat of a pair read is ignored and produces no response.
- R9: Every read reflects the visible buffer as it stood at the edge where the request was sampled. A read sampled on the transfer edge returns only old data, and this holds for both bytes of a pair read.
- R10: Addresses 24 and above read as zero, and writes to them have no effect.
- R11: After reset the visible buffer is all zero, and `rvalid_o` and `xfer_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frm_valid_i | input | 1 | One decoded frame present this cycle |
| frm_start_i | input | 1 | Frame carries the block start marker |
| cs_a_i | input | 1 | Channel status bit, channel A |
| cs_b_i | input | 1 | Channel status bit, channel B |
| reserve_i | input | 1 | Protect bytes 0..4 from transfers |
| req_i | input | 1 | Host access request |
| we_i | input | 1 | 1 = write, 0 = read |
| pair_i | input | 1 | Read returns A then B bytes |
| chan_sel_i | input | 1 | Channel for one-byte reads and writes (0 = A) |
| addr_i | input | 5 | Byte index |
| wdata_i | input | 8 | Write byte |
| rvalid_o | output | 1 | Read byte valid |
| rdata_o | output | 8 | Read byte |
| xfer_o | output | 1 | Block transfer in progress |

## Verification
Two pairs of events can fall in the same cycle. A host read and a block transfer can both be sampled on one edge, and so can a host write and a block transfer. The bench provokes each case by issuing the access in the cycle right after the frame that completes a block. A pair read issued there must return the old A and B bytes. A write issued there must survive the copy. The bench also checks that reserved bytes keep host data across a later transfer while the bytes around them are replaced.

// File: rtl/cs_buf_pkg.sv
package cs_buf_pkg;
  typedef enum logic {
    CH_A = 1'b0,
    CH_B = 1'b1
  } cs_chan_e;
endpackage

// File: rtl/cs_frame_track.sv
module cs_frame_track #(
  parameter int BLOCK_FRAMES = 192,
  localparam int CW = $clog2(BLOCK_FRAMES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frm_valid_i,
  input  logic          frm_start_i,
  output logic          wr_en_o,
  output logic [CW-1:0] wr_idx_o,
  output logic          xfer_o
);
  localparam logic [CW-1:0] LAST = CW'(BLOCK_FRAMES - 1);

  logic [CW-1:0] cnt_q;
  logic          sync_q;
  logic          xfer_q;

  assign wr_en_o  = frm_valid_i;
  assign wr_idx_o = frm_start_i ? '0 : cnt_q;
  assign xfer_o   = xfer_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sync_q <= 1'b0;
      xfer_q <= 1'b0;
    end else begin
      xfer_q <= 1'b0;
      if (frm_valid_i) begin
        if (frm_start_i) begin
          cnt_q  <= CW'(1);
          sync_q <= 1'b1;
        end else if (cnt_q == '0) begin
          // wrapped without a start marker: alignment lost
          cnt_q  <= CW'(1);
          sync_q <= 1'b0;
        end else if (cnt_q == LAST) begin
          cnt_q  <= '0;
          xfer_q <= sync_q;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  AST_XFER_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_q |=> !xfer_q); // R2
  AST_START_NO_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_valid_i && frm_start_i) |=> !xfer_q); // R3
endmodule

// File: rtl/cs_assemble.sv
module cs_assemble #(
  parameter int BLOCK_FRAMES = 192,
  localparam int NBYTES = BLOCK_FRAMES / 8,
  localparam int CW = $clog2(BLOCK_FRAMES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [CW-1:0]          wr_idx_i,
  input  logic                   cs_a_i,
  input  logic                   cs_b_i,
  output logic [NBYTES-1:0][7:0] asm_a_o,
  output logic [NBYTES-1:0][7:0] asm_b_o
);
  logic [BLOCK_FRAMES-1:0] bits_a_q, bits_b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bits_a_q <= '0;
      bits_b_q <= '0;
    end else if (wr_en_i) begin
      bits_a_q[wr_idx_i] <= cs_a_i;
      bits_b_q[wr_idx_i] <= cs_b_i;
    end
  end

  // flat index n maps to byte n/8, bit n%8
  assign asm_a_o = bits_a_q;
  assign asm_b_o = bits_b_q;
endmodule

// File: rtl/cs_vis_buf.sv
module cs_vis_buf
  import cs_buf_pkg::*;
#(
  parameter int BLOCK_FRAMES = 192,
  parameter int RSV_BYTES = 5,
  localparam int NBYTES = BLOCK_FRAMES / 8,
  localparam int AW = $clog2(NBYTES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   xfer_i,
  input  logic                   reserve_i,
  input  logic [NBYTES-1:0][7:0] asm_a_i,
  input  logic [NBYTES-1:0][7:0] asm_b_i,
  input  logic                   wr_en_i,
  input  cs_chan_e               wr_ch_i,
  input  logic [AW-1:0]          wr_addr_i,
  input  logic [7:0]             wr_data_i,
  output logic [NBYTES-1:0][7:0] vis_a_o,
  output logic [NBYTES-1:0][7:0] vis_b_o
);
  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    localparam bit IS_RSV = (g < RSV_BYTES);
    logic hit;
    logic take;
    assign hit  = wr_en_i && (wr_addr_i == AW'(g));
    assign take = xfer_i && !(IS_RSV && reserve_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vis_a_o[g] <= '0;
        vis_b_o[g] <= '0;
      end else begin
        if (take) begin
          vis_a_o[g] <= asm_a_i[g];
          vis_b_o[g] <= asm_b_i[g];
        end
        // host write has priority over the block copy
        if (hit && wr_ch_i == CH_A) vis_a_o[g] <= wr_data_i;
        if (hit && wr_ch_i == CH_B) vis_b_o[g] <= wr_data_i;
      end
    end

    AST_WR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit && wr_ch_i == CH_B) |=> (vis_b_o[g] == $past(wr_data_i))); // R5

    if (IS_RSV) begin : g_rsv
      AST_RSV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (xfer_i && reserve_i && !hit) |=> ($stable(vis_a_o[g]) && $stable(vis_b_o[g]))); // R4
    end
  end
endmodule

// File: rtl/cs_read_port.sv
module cs_read_port #(
  parameter int BLOCK_FRAMES = 192,
  localparam int NBYTES = BLOCK_FRAMES / 8,
  localparam int AW = $clog2(NBYTES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   rd_req_i,
  input  logic                   pair_i,
  input  logic                   sel_i,
  input  logic [AW-1:0]          addr_i,
  input  logic [NBYTES-1:0][7:0] vis_a_i,
  input  logic [NBYTES-1:0][7:0] vis_b_i,
  output logic                   rvalid_o,
  output logic [7:0]             rdata_o
);
  logic       in_range;
  logic [7:0] byte_a, byte_b;
  logic       beat2_q;
  logic [7:0] hold_b_q;

  assign in_range = (32'(addr_i) < NBYTES);
  assign byte_a   = in_range ? vis_a_i[addr_i] : 8'h00;
  assign byte_b   = in_range ? vis_b_i[addr_i] : 8'h00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
      beat2_q  <= 1'b0;
      hold_b_q <= '0;
    end else begin
      rvalid_o <= 1'b0;
      beat2_q  <= 1'b0;
      if (beat2_q) begin
        rvalid_o <= 1'b1;
        rdata_o  <= hold_b_q;
      end else if (rd_req_i) begin
        // both bytes snapshotted on the request edge
        rvalid_o <= 1'b1;
        rdata_o  <= (pair_i || !sel_i) ? byte_a : byte_b;
        hold_b_q <= byte_b;
        beat2_q  <= pair_i;
      end
    end
  end

  AST_RD_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && !beat2_q) |=> rvalid_o); // R6
  AST_PAIR_SECOND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && !beat2_q && pair_i) |=> ##1 rvalid_o); // R7
  AST_BEAT2_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat2_q |=> !beat2_q); // R8
  AST_OOR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && !beat2_q && !in_range) |=> (rdata_o == 8'h00)); // R10
endmodule

// File: rtl/cs_block_buffer.sv
module cs_block_buffer
  import cs_buf_pkg::*;
#(
  parameter int BLOCK_FRAMES = 192,
  parameter int RSV_BYTES = 5,
  localparam int NBYTES = BLOCK_FRAMES / 8,
  localparam int AW = $clog2(NBYTES),
  localparam int CW = $clog2(BLOCK_FRAMES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frm_valid_i,
  input  logic          frm_start_i,
  input  logic          cs_a_i,
  input  logic          cs_b_i,
  input  logic          reserve_i,
  input  logic          req_i,
  input  logic          we_i,
  input  logic          pair_i,
  input  logic          chan_sel_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic          rvalid_o,
  output logic [7:0]    rdata_o,
  output logic          xfer_o
);
  logic                   wr_en;
  logic [CW-1:0]          wr_idx;
  logic                   xfer;
  logic [NBYTES-1:0][7:0] asm_a, asm_b, vis_a, vis_b;
  cs_chan_e               ch;

  assign ch     = cs_chan_e'(chan_sel_i);
  assign xfer_o = xfer;

  cs_frame_track #(.BLOCK_FRAMES(BLOCK_FRAMES)) i_track (
    .clk_i, .rst_ni, .frm_valid_i, .frm_start_i,
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .xfer_o(xfer)
  );

  cs_assemble #(.BLOCK_FRAMES(BLOCK_FRAMES)) i_asm (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .cs_a_i, .cs_b_i, .asm_a_o(asm_a), .asm_b_o(asm_b)
  );

  cs_vis_buf #(.BLOCK_FRAMES(BLOCK_FRAMES), .RSV_BYTES(RSV_BYTES)) i_vis (
    .clk_i, .rst_ni, .xfer_i(xfer), .reserve_i,
    .asm_a_i(asm_a), .asm_b_i(asm_b),
    .wr_en_i(req_i && we_i), .wr_ch_i(ch), .wr_addr_i(addr_i), .wr_data_i(wdata_i),
    .vis_a_o(vis_a), .vis_b_o(vis_b)
  );

  cs_read_port #(.BLOCK_FRAMES(BLOCK_FRAMES)) i_rd (
    .clk_i, .rst_ni, .rd_req_i(req_i && !we_i), .pair_i, .sel_i(chan_sel_i),
    .addr_i, .vis_a_i(vis_a), .vis_b_i(vis_b), .rvalid_o, .rdata_o
  );
endmodule

// File: tb/test_cs_block_buffer.sv
module test_cs_block_buffer;
  timeunit 1ns;
  timeprecision 1ps;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic frm_valid, frm_start, cs_a, cs_b, reserve, req, we, pair, chan_sel;
  logic [4:0] addr;
  logic [7:0] wdata;
  logic rvalid, xfer;
  logic [7:0] rdata;

  always #5 clk = ~clk;

  cs_block_buffer i_cs_block_buffer (
    .clk_i(clk), .rst_ni, .frm_valid_i(frm_valid), .frm_start_i(frm_start),
    .cs_a_i(cs_a), .cs_b_i(cs_b), .reserve_i(reserve), .req_i(req), .we_i(we),
    .pair_i(pair), .chan_sel_i(chan_sel), .addr_i(addr), .wdata_i(wdata),
    .rvalid_o(rvalid), .rdata_o(rdata), .xfer_o(xfer)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit [7:0] exp_q[$];
  string    tag_q[$];

  // requirement-level model
  bit [7:0] m_vis_a[24], m_vis_b[24], m_asm_a[24], m_asm_b[24];
  int m_cnt = 0;
  bit m_sync = 0, m_pend = 0, m_beat2 = 0, prev_beat2 = 0;
  string xtag = "R2";

  function automatic bit [7:0] pat_a(int s, int k); return 8'(s * 37 + k * 11 + 5); endfunction
  function automatic bit [7:0] pat_b(int s, int k); return 8'((s * 53) ^ (k * 29 + 3)); endfunction

  task automatic check(string r, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_ni && rvalid) begin
      if (exp_q.size() == 0) check("R8 unexpected response", 1, 0);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic op_begin();
    @(negedge clk);
    check(xtag, xfer, m_pend);
    frm_valid = 0; frm_start = 0; req = 0; we = 0; pair = 0;
    prev_beat2 = m_beat2; m_beat2 = 0;
  endtask

  task automatic model_edge();
    if (m_pend) begin
      for (int i = 0; i < 24; i++)
        if (!(reserve && i < 5)) begin m_vis_a[i] = m_asm_a[i]; m_vis_b[i] = m_asm_b[i]; end
      m_pend = 0;
    end
  endtask

  task automatic t_idle();
    op_begin(); model_edge();
  endtask

  task automatic t_frame(bit st, bit a, bit b);
    int idx;
    op_begin();
    frm_valid = 1; frm_start = st; cs_a = a; cs_b = b;
    model_edge();
    if (st) begin idx = 0; m_sync = 1; m_cnt = 1; end
    else if (m_cnt == 0) begin idx = 0; m_sync = 0; m_cnt = 1; end
    else begin
      idx = m_cnt;
      if (m_cnt == 191) begin m_pend = m_sync; m_cnt = 0; end
      else m_cnt++;
    end
    m_asm_a[idx/8][idx%8] = a;
    m_asm_b[idx/8][idx%8] = b;
  endtask

  task automatic t_read(int ad, bit pr, bit sel, string r);
    op_begin();
    req = 1; we = 0; pair = pr; chan_sel = sel; addr = 5'(ad);
    if (!prev_beat2) begin
      bit [7:0] va, vb;
      va = (ad < 24) ? m_vis_a[ad] : 8'h00;
      vb = (ad < 24) ? m_vis_b[ad] : 8'h00;
      exp_q.push_back((pr || !sel) ? va : vb); tag_q.push_back(r);
      if (pr) begin exp_q.push_back(vb); tag_q.push_back(r); m_beat2 = 1; end
    end
    model_edge();
  endtask

  task automatic t_write(int ad, bit ch, bit [7:0] d);
    op_begin();
    req = 1; we = 1; chan_sel = ch; addr = 5'(ad); wdata = d;
    model_edge();
    if (ad < 24) begin
      if (ch) m_vis_b[ad] = d; else m_vis_a[ad] = d;
    end
  endtask

  task automatic send_frames(int s, int first, int n, bit st);
    for (int f = first; f < first + n; f++)
      t_frame(st && f == first, pat_a(s, f/8)[f%8], pat_b(s, f/8)[f%8]);
  endtask

  task automatic read_pairs(string r);
    foreach (exp_q[i]) ; // keep queue untouched
    for (int k = 0; k < 24; k += 5) begin t_read(k, 1, 0, r); t_idle(); end
  endtask

  initial begin
    frm_valid = 0; frm_start = 0; cs_a = 0; cs_b = 0; reserve = 0;
    req = 0; we = 0; pair = 0; chan_sel = 0; addr = 0; wdata = 0;
    foreach (m_vis_a[i]) begin m_vis_a[i] = 0; m_vis_b[i] = 0; m_asm_a[i] = 0; m_asm_b[i] = 0; end
    repeat (3) @(negedge clk);
    check("R11 rvalid", rvalid, 0);
    check("R11 xfer", xfer, 0);
    rst_ni = 1;
    t_read(0, 0, 0, "R11"); t_read(23, 1, 0, "R11"); t_idle();
    // host writes and reads
    t_write(3, 0, 8'h5A); t_write(3, 1, 8'hC3);
    t_read(3, 0, 0, "R5"); t_read(3, 0, 1, "R6"); t_read(3, 1, 0, "R7"); t_idle();
    // block 1: mid-block read sees old data, read on copy edge sees old
    send_frames(1, 0, 101, 1);
    t_read(12, 1, 0, "R1"); t_idle();
    send_frames(1, 101, 91, 0);
    t_read(10, 1, 0, "R9"); t_idle();
    read_pairs("R1");
    t_read(23, 0, 1, "R2");
    // block 2 with reserve: write on copy edge wins
    t_write(2, 0, 8'hEE); t_write(4, 1, 8'h11);
    reserve = 1;
    send_frames(2, 0, 192, 1);
    t_write(8, 1, 8'h77);
    t_read(2, 1, 0, "R4"); t_idle(); t_read(4, 1, 0, "R4"); t_idle();
    t_read(0, 1, 0, "R4"); t_idle(); t_read(5, 1, 0, "R4"); t_idle();
    t_read(8, 1, 0, "R5"); t_idle();
    reserve = 0;
    // restart mid-block, then full block, then block without start
    xtag = "R3";
    send_frames(3, 0, 100, 1);
    send_frames(4, 0, 192, 1);
    t_idle();
    read_pairs("R3");
    send_frames(5, 0, 192, 0);
    send_frames(5, 0, 30, 0);
    read_pairs("R3");
    xtag = "R2";
    // ignored request during second beat
    t_read(4, 1, 0, "R8"); t_read(5, 0, 0, "R8"); t_idle(); t_read(6, 0, 1, "R8");
    // out of range
    t_read(30, 1, 0, "R10"); t_idle();
    t_write(30, 0, 8'hFF); t_read(30, 0, 0, "R10"); t_read(31, 0, 1, "R10");
    repeat (4) t_idle();
    check("R8 pending responses", exp_q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule